// File: doc/BRIEF.md
# Tagged Address Translation Buffer

This block is a small fully associative translation buffer that sits beside a processor pipeline and turns 32-bit virtual addresses into physical addresses. Every entry is tagged with a process identifier, so address spaces of several processes can live in the buffer at once and a context switch does not require emptying it. Every matching entry is also checked against its read and write rights, so a lookup yields exactly one of three outcomes: a hit with a translated address, a miss, or a protection fault.

Lookups are combinational and one may be issued every cycle. When a miss is reported, an external handler reads the page table and writes the entry back through the refill port. Maintenance commands can empty the whole buffer or only the entries of one process. On each cycle a small decoder picks one maintenance operation: NONE, REFILL, FLUSH_PID or FLUSH_ALL. The decision is made anew each cycle, and a flush always beats a refill.

Top module: `tagged_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the entry's physical page number concatenated with `lk_vaddr[11:0]` (bits 31:12 are the virtual page number, bits 11:0 the untranslated offset); when there is no hit, `lk_paddr` is zero.
- R2: A lookup hits if any valid entry, in any slot, has the same virtual page number and the same process identifier as `lk_pid`, and the access is permitted.
- R3: An entry whose process identifier differs from `lk_pid` never matches. Entries for the same page under different identifiers coexist.
- R4: A load (`lk_store`=0) on a matching entry without read right, or a store (`lk_store`=1) on one without write right, raises `lk_fault` and not `lk_hit`.
- R5: A valid lookup with no matching valid entry raises `lk_miss`.
- R6: A refill with no matching entry goes to the lowest-numbered invalid slot. If all slots are valid, it goes to the slot named by a round-robin pointer, which starts at 0 after reset and advances by one (wrapping) after each such eviction. A refilled entry is visible to lookups from the next cycle.
- R7: A refill whose page number and process identifier match a valid entry overwrites that entry in place. No duplicate entry is ever created.
- R8: `fl_all` invalidates every entry; lookups miss from the next cycle.
- R9: `fl_pid_en` invalidates only the entries whose process identifier equals `fl_pid`.
- R10: In one cycle, `fl_all` takes precedence over `fl_pid_en`, and either flush takes precedence over `rf_valid`. The lower-priority request in that cycle is ignored.
- R11: `lk_hit`, `lk_miss` and `lk_fault` are mutually exclusive. Exactly one is high when `lk_valid` is high, and all are low when it is low.
- R12: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| lk_pid | input | PID_W | Current process identifier |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry lacks the access right |
| lk_paddr | output | PPN_W+12 | Translated physical address |
| rf_valid | input | 1 | Refill write request |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pid | input | PID_W | Refill process identifier |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_rd | input | 1 | Refill read right |
| rf_wr | input | 1 | Refill write right |
| fl_all | input | 1 | Invalidate all entries |
| fl_pid_en | input | 1 | Invalidate entries of one process |
| fl_pid | input | PID_W | Process identifier to invalidate |

## Verification
Lookup results depend only on the current lookup inputs and the stored entries, so they are due in the same cycle as the request. The bench compares them half a cycle after the inputs change, at the falling edge. Refills and flushes take effect at the next rising edge and show in the first lookup after it. The reference model in the bench therefore applies the maintenance request only after the comparison at each falling edge. Eviction order and flush selectivity are observed indirectly, as hits and misses on later lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_REFILL    = 2'd1,
        OP_FLUSH_PID = 2'd2,
        OP_FLUSH_ALL = 2'd3
    } maint_op_e;
endpackage

// File: rtl/tlb_maint_dec.sv
module tlb_maint_dec
    import tlb_pkg::*;
(
    input  logic      fl_all,
    input  logic      fl_pid_en,
    input  logic      rf_valid,
    output maint_op_e op
);
    // Priority: full flush, then selective flush, then refill (R10)
    always_comb begin
        unique casez ({fl_all, fl_pid_en, rf_valid})
            3'b1??:  op = OP_FLUSH_ALL;
            3'b01?:  op = OP_FLUSH_PID;
            3'b001:  op = OP_REFILL;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_refill,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] rf_match,
    output logic [IDX_W-1:0]   widx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;
    logic             evict;

    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (rf_match[i])   match_idx = IDX_W'(i);
            if (!valid_vec[i]) free_idx  = IDX_W'(i);
        end
        any_match = |rf_match;
        any_free  = ~&valid_vec;
        evict     = do_refill && !any_match && !any_free;
        if (any_match)     widx = match_idx;
        else if (any_free) widx = free_idx;
        else               widx = rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (evict)
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end

    // R6
    rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rr_q) < ENTRIES);

    // R7
    refill_match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rf_match));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  maint_op_e          op,
    input  logic [IDX_W-1:0]   widx,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic [PID_W-1:0]   rf_pid,
    input  logic [PPN_W-1:0]   rf_ppn,
    input  logic               rf_rd,
    input  logic               rf_wr,
    input  logic [PID_W-1:0]   fl_pid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [PID_W-1:0]   lk_pid,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] rf_match,
    output logic [PPN_W-1:0]   sel_ppn,
    output logic               sel_rd,
    output logic               sel_wr
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] rd_q;
    logic [ENTRIES-1:0] wr_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PID_W-1:0]   pid_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                rd_q[i]    <= 1'b0;
                wr_q[i]    <= 1'b0;
                vpn_q[i]   <= '0;
                pid_q[i]   <= '0;
                ppn_q[i]   <= '0;
            end else begin
                unique case (op)
                    OP_FLUSH_ALL: valid_q[i] <= 1'b0;
                    OP_FLUSH_PID: if (pid_q[i] == fl_pid) valid_q[i] <= 1'b0;
                    OP_REFILL: begin
                        if (widx == IDX_W'(i)) begin
                            valid_q[i] <= 1'b1;
                            rd_q[i]    <= rf_rd;
                            wr_q[i]    <= rf_wr;
                            vpn_q[i]   <= rf_vpn;
                            pid_q[i]   <= rf_pid;
                            ppn_q[i]   <= rf_ppn;
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign lk_match[i] = valid_q[i] && vpn_q[i] == lk_vpn && pid_q[i] == lk_pid;
        assign rf_match[i] = valid_q[i] && vpn_q[i] == rf_vpn && pid_q[i] == rf_pid;

        // R9
        flush_pid_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_FLUSH_PID && pid_q[i] != fl_pid && valid_q[i]) |=> valid_q[i]);
    end

    assign valid_vec = valid_q;

    always_comb begin
        sel_ppn = '0;
        sel_rd  = 1'b0;
        sel_wr  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_ppn = sel_ppn | ppn_q[i];
                sel_rd  = sel_rd  | rd_q[i];
                sel_wr  = sel_wr  | wr_q[i];
            end
        end
    end

    // R7
    no_dup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8
    flush_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_ALL) |=> (valid_q == '0));

    // R12
    reset_empty_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic               lk_store,
    input  logic [PID_W-1:0]   lk_pid,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic               lk_fault,
    output logic [PA_W-1:0]    lk_paddr,
    input  logic               rf_valid,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic [PID_W-1:0]   rf_pid,
    input  logic [PPN_W-1:0]   rf_ppn,
    input  logic               rf_rd,
    input  logic               rf_wr,
    input  logic               fl_all,
    input  logic               fl_pid_en,
    input  logic [PID_W-1:0]   fl_pid
);
    maint_op_e          op;
    logic [IDX_W-1:0]   widx;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] rf_match;
    logic [PPN_W-1:0]   sel_ppn;
    logic               sel_rd;
    logic               sel_wr;
    logic               any_hit;
    logic               allowed;

    tlb_maint_dec u_dec (
        .fl_all    (fl_all),
        .fl_pid_en (fl_pid_en),
        .rf_valid  (rf_valid),
        .op        (op)
    );

    tlb_store #(
        .ENTRIES (ENTRIES),
        .PID_W   (PID_W),
        .PPN_W   (PPN_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .widx      (widx),
        .rf_vpn    (rf_vpn),
        .rf_pid    (rf_pid),
        .rf_ppn    (rf_ppn),
        .rf_rd     (rf_rd),
        .rf_wr     (rf_wr),
        .fl_pid    (fl_pid),
        .lk_vpn    (lk_vaddr[VA_W-1:OFF_W]),
        .lk_pid    (lk_pid),
        .valid_vec (valid_vec),
        .lk_match  (lk_match),
        .rf_match  (rf_match),
        .sel_ppn   (sel_ppn),
        .sel_rd    (sel_rd),
        .sel_wr    (sel_wr)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_refill (op == OP_REFILL),
        .valid_vec (valid_vec),
        .rf_match  (rf_match),
        .widx      (widx)
    );

    always_comb begin
        any_hit  = |lk_match;
        allowed  = lk_store ? sel_wr : sel_rd;
        lk_hit   = lk_valid && any_hit && allowed;
        lk_fault = lk_valid && any_hit && !allowed;
        lk_miss  = lk_valid && !any_hit;
        lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
    end

    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    // R8
    miss_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> !(lk_hit || lk_fault));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
endmodule

// File: tb/tb_tagged_tlb.sv
`timescale 1ns/1ps
module tb_tagged_tlb;
    localparam int N     = 16;
    localparam int PID_W = 8;
    localparam int PPN_W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_store = 0, rf_valid = 0, rf_rd = 0, rf_wr = 0;
    logic fl_all = 0, fl_pid_en = 0;
    logic [31:0] lk_vaddr = '0;
    logic [PID_W-1:0] lk_pid = '0, rf_pid = '0, fl_pid = '0;
    logic [19:0] rf_vpn = '0;
    logic [PPN_W-1:0] rf_ppn = '0;
    logic lk_hit, lk_miss, lk_fault;
    logic [PPN_W+11:0] lk_paddr;

    int checks = 0;
    int errors = 0;
    bit run = 0;
    string cur_req = "R12";

    // behavioural reference state
    bit               m_v   [N];
    bit               m_r   [N];
    bit               m_w   [N];
    logic [19:0]      m_vpn [N];
    logic [PID_W-1:0] m_pid [N];
    logic [PPN_W-1:0] m_ppn [N];
    int               m_rr = 0;

    always #2 clk = ~clk;

    tagged_tlb #(.ENTRIES(N), .PID_W(PID_W), .PPN_W(PPN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store), .lk_pid(lk_pid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pid(rf_pid), .rf_ppn(rf_ppn),
        .rf_rd(rf_rd), .rf_wr(rf_wr),
        .fl_all(fl_all), .fl_pid_en(fl_pid_en), .fl_pid(fl_pid)
    );

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    // compare at the falling edge, then apply this cycle's maintenance
    always @(negedge clk) begin
        if (run) begin
            int idx;
            bit eh, em, ef;
            logic [31:0] ep;
            idx = -1;
            for (int k = 0; k < N; k++)
                if (m_v[k] && m_vpn[k] == lk_vaddr[31:12] && m_pid[k] == lk_pid) idx = k;
            eh = 0; em = 0; ef = 0; ep = '0;
            if (lk_valid) begin
                if (idx < 0) em = 1;
                else if (lk_store ? m_w[idx] : m_r[idx]) begin
                    eh = 1;
                    ep = {m_ppn[idx], lk_vaddr[11:0]};
                end else ef = 1;
            end
            chk("hit", 32'(lk_hit), 32'(eh));
            chk("miss", 32'(lk_miss), 32'(em));
            chk("fault", 32'(lk_fault), 32'(ef));
            chk("paddr", 32'(lk_paddr), ep);

            if (fl_all) begin
                for (int k = 0; k < N; k++) m_v[k] = 0;
            end else if (fl_pid_en) begin
                for (int k = 0; k < N; k++) if (m_pid[k] == fl_pid) m_v[k] = 0;
            end else if (rf_valid) begin
                int slot;
                slot = -1;
                for (int k = 0; k < N; k++)
                    if (m_v[k] && m_vpn[k] == rf_vpn && m_pid[k] == rf_pid) slot = k;
                if (slot < 0)
                    for (int k = N - 1; k >= 0; k--) if (!m_v[k]) slot = k;
                if (slot < 0) begin
                    slot = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_v[slot] = 1; m_r[slot] = rf_rd; m_w[slot] = rf_wr;
                m_vpn[slot] = rf_vpn; m_pid[slot] = rf_pid; m_ppn[slot] = rf_ppn;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        lk_valid = 0; rf_valid = 0; fl_all = 0; fl_pid_en = 0;
    endtask

    task automatic lookup(logic [19:0] vpn, logic [11:0] off, logic [PID_W-1:0] p, bit st);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_pid = p; lk_store = st;
        step();
    endtask

    task automatic refill(logic [19:0] vpn, logic [PID_W-1:0] p, logic [PPN_W-1:0] ppn, bit r, bit w);
        rf_valid = 1; rf_vpn = vpn; rf_pid = p; rf_ppn = ppn; rf_rd = r; rf_wr = w;
        step();
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            m_v[k] = 0; m_r[k] = 0; m_w[k] = 0; m_vpn[k] = '0; m_pid[k] = '0; m_ppn[k] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1; run = 1;

        cur_req = "R12"; lookup(20'h00000, 12'h000, 8'd0, 0); lookup(20'h12345, 12'h678, 8'd1, 1);
        cur_req = "R11"; step(); step();

        cur_req = "R2";
        refill(20'hABCDE, 8'd1, 20'h11111, 1, 1);
        refill(20'h00042, 8'd1, 20'h22222, 1, 1);
        lookup(20'hABCDE, 12'h123, 8'd1, 0);
        lookup(20'h00042, 12'hFFF, 8'd1, 1);
        cur_req = "R1"; lookup(20'hABCDE, 12'hA5A, 8'd1, 1);

        cur_req = "R3";
        lookup(20'hABCDE, 12'h010, 8'd2, 0);
        refill(20'hABCDE, 8'd2, 20'h33333, 1, 0);
        lookup(20'hABCDE, 12'h010, 8'd2, 0);
        lookup(20'hABCDE, 12'h010, 8'd1, 0);

        cur_req = "R4";
        lookup(20'hABCDE, 12'h020, 8'd2, 1);
        refill(20'h0BEEF, 8'd4, 20'h44444, 0, 1);
        lookup(20'h0BEEF, 12'h030, 8'd4, 0);
        lookup(20'h0BEEF, 12'h030, 8'd4, 1);
        refill(20'h0DEAD, 8'd4, 20'h55555, 0, 0);
        lookup(20'h0DEAD, 12'h000, 8'd4, 0);

        cur_req = "R5"; lookup(20'h77777, 12'h000, 8'd1, 0);

        cur_req = "R7";
        refill(20'hABCDE, 8'd1, 20'h66666, 1, 0);
        lookup(20'hABCDE, 12'h444, 8'd1, 0);
        lookup(20'hABCDE, 12'h444, 8'd1, 1);

        cur_req = "R9";
        fl_pid_en = 1; fl_pid = 8'd2; step();
        lookup(20'hABCDE, 12'h001, 8'd2, 0);
        lookup(20'hABCDE, 12'h001, 8'd1, 0);
        lookup(20'h0BEEF, 12'h001, 8'd4, 1);

        cur_req = "R10";
        fl_all = 1; rf_valid = 1; rf_vpn = 20'h99999; rf_pid = 8'd1; rf_ppn = 20'h1; rf_rd = 1; rf_wr = 1;
        step();
        lookup(20'h99999, 12'h000, 8'd1, 0);
        refill(20'h10000, 8'd5, 20'h2, 1, 1);
        fl_pid_en = 1; fl_pid = 8'd7; rf_valid = 1; rf_vpn = 20'h10001; rf_pid = 8'd5; rf_ppn = 20'h3; rf_rd = 1; rf_wr = 1;
        step();
        lookup(20'h10001, 12'h000, 8'd5, 0);
        lookup(20'h10000, 12'h000, 8'd5, 0);

        cur_req = "R8";
        fl_all = 1; step();
        lookup(20'h10000, 12'h000, 8'd5, 0);

        cur_req = "R6";
        for (int k = 0; k < N; k++) refill(20'h00100 + 20'(k), 8'd3, 20'h00500 + 20'(k), 1, 1);
        for (int k = 0; k < N; k++) lookup(20'h00100 + 20'(k), 12'h0C0, 8'd3, 0);
        for (int k = 0; k < N + 3; k++) refill(20'h00200 + 20'(k), 8'd3, 20'h00900 + 20'(k), 1, 1);
        for (int k = 0; k < N; k++) lookup(20'h00100 + 20'(k), 12'h0C0, 8'd3, 0);
        for (int k = 0; k < N + 3; k++) lookup(20'h00200 + 20'(k), 12'h0C0, 8'd3, 1);
        fl_pid_en = 1; fl_pid = 8'd3; step();
        refill(20'h00300, 8'd6, 20'h00AAA, 1, 1);
        lookup(20'h00300, 12'h111, 8'd6, 0);

        run = 0;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule